// File: doc/BRIEF.md
# Asynchronous DRAM Access Controller

This block sits between a synchronous host and an asynchronous DRAM of 256K words by 8 bits whose address pins are shared between row and column. The host presents an 18-bit word address, a write flag and write data, holds its request high and receives a one-cycle completion pulse, with read data alongside it for reads. The controller splits the address into a row half (bits 17:9) and a column half (bits 8:0). It sequences the active-low row strobe, column strobe, write enable and output enable on the nine address pins, and it drives an enable for the tristate data buffer during writes.

A configuration input selects the cycle style. In the early style the output enable (read) or write enable (write) falls one cycle before the column strobe. In the late style it falls one cycle after the column strobe. A built-in scheduler issues row-only refresh cycles to the 512 rows in turn. It spaces them evenly over 8 ms using a clock-frequency parameter. A pending refresh wins over a waiting host request but never cuts into an access that has already started. The precharge time, the row-to-column delay and the column strobe width are parameters counted in clock cycles.

The state machine has seven states. IDLE goes to REFRESH when a refresh is pending, otherwise to ROW when a request is present. ROW goes to COL after T_RCD cycles. COL goes to CAS_ONLY in late style or to STROBE in early style. CAS_ONLY goes to STROBE. STROBE goes to PRECHARGE after T_CAS cycles. REFRESH goes to PRECHARGE after T_RCD+T_CAS cycles. PRECHARGE returns to IDLE after T_RP cycles.

Top module: `dram_async_ctrl`

## Requirements
- R1: While reset is held, all four strobes are high, the data-drive enable is low and the completion pulse is low.
- R2: Every access starts with the row strobe falling while the row half (address bits 17:9) is on the pins. At least T_RCD cycles later the column strobe falls with the column half (bits 8:0) on the pins. The column strobe is only ever low while the row strobe is low.
- R3: With the style input at 0 (early), output enable for a read or write enable for a write is already low when the column strobe falls.
- R4: With the style input at 1 (late), output enable and write enable are both still high when the column strobe falls, and the one for the access falls afterwards.
- R5: During a write, the data-drive enable is high with the write data on the data outputs whenever write enable, row strobe and column strobe are all low. The data-drive enable is never high while output enable is low. Output enable and write enable are never low together.
- R6: A read returns the byte stored at the addressed location on rd_data, valid in the cycle of the completion pulse.
- R7: The row strobe stays high for at least T_RP cycles before each fall. The column strobe stays low for at least T_CAS cycles.
- R8: Refresh cycles drop only the row strobe. They visit rows 0,1,...,511 and wrap to 0. One is issued per interval of (CLK_HZ/1000)*REFRESH_MS/512 cycles.
- R9: A refresh that falls due while the host keeps requests coming starts no later than one access after it falls due. An access in progress is never interrupted.
- R10: The completion pulse lasts exactly one cycle. It comes after the strobes are all released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until done |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address (row = 17:9, column = 8:0) |
| req_wdata | input | 8 | Write data |
| late_mode | input | 1 | 0 = early style, 1 = late style |
| rd_data | output | 8 | Read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| dram_addr | output | 9 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data driven toward the device |
| dram_dq_oe | output | 1 | Enable for the tristate data buffer |
| dram_dq_in | input | 8 | Data returned from the device |

## Verification
The assertions check the following on every cycle:
- the column strobe is only low while the row strobe is low;
- the early or late ordering of the enables against the falling column strobe;
- output enable and write enable are never low together, and the data buffer is never enabled while output enable is low;
- the minimum row-high and column-low widths;
- the completion pulse lasts one cycle and arrives with all strobes high.

Only the bench scenarios can show the rest:
- that the row and column halves on the pins match the requested address;
- that read data matches earlier writes;
- the refresh row sequence, including its wrap past 511;
- the refresh rate;
- that refresh is not starved under back-to-back host traffic.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS_ONLY,
        ST_STROBE,
        ST_REFRESH,
        ST_PRECHARGE
    } dram_state_t;

endpackage

// File: rtl/dram_phase_timer.sv
// Down-counter that holds a controller phase for a loaded number of cycles.
module dram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dram_refresh_sched.sv
// Interval counter and row pointer for row-only refresh.
module dram_refresh_sched #(
    parameter int INTERVAL = 781,
    parameter int ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);

    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CNT_W-1:0] tick_cnt_q;
    logic             tick;
    logic             pending_q;
    logic [ROW_W-1:0] row_q;

    assign tick = (tick_cnt_q == CNT_W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
            pending_q  <= 1'b0;
            row_q      <= '0;
        end else begin
            tick_cnt_q <= tick ? '0 : tick_cnt_q + CNT_W'(1);
            pending_q  <= (pending_q & ~ack) | tick;
            if (ack) begin
                row_q <= row_q + ROW_W'(1);
            end
        end
    end

    assign pending = pending_q;
    assign row     = row_q;

endmodule

// File: rtl/dram_async_ctrl.sv
module dram_async_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int REFRESH_MS = 8,
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter int T_RP       = 3,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  late_mode,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  done,
    output logic [ADDR_W/2-1:0]   dram_addr,
    output logic                  dram_ras_n,
    output logic                  dram_cas_n,
    output logic                  dram_we_n,
    output logic                  dram_oe_n,
    output logic [DATA_W-1:0]     dram_dq_out,
    output logic                  dram_dq_oe,
    input  logic [DATA_W-1:0]     dram_dq_in
);

    localparam int PIN_W        = ADDR_W / 2;
    localparam int ROWS         = 2 ** PIN_W;
    localparam int REF_INTERVAL = (CLK_HZ / 1000) * REFRESH_MS / ROWS;
    localparam int REF_LEN      = T_RCD + T_CAS;
    localparam int MAX_LEN      = (REF_LEN > T_RP) ? REF_LEN : T_RP;
    localparam int TMR_W        = $clog2(MAX_LEN + 1);

    dram_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              is_wr_q;
    logic              late_q;
    logic              done_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              ref_pending;
    logic              ref_ack;
    logic [PIN_W-1:0]  ref_row;
    logic              accept;
    logic              finish;

    dram_phase_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dram_refresh_sched #(
        .INTERVAL (REF_INTERVAL),
        .ROW_W    (PIN_W)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending),
        .row     (ref_row)
    );

    // Next-state and phase-length selection
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(1);
        ref_ack  = 1'b0;
        accept   = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d  = ST_REFRESH;
                    ref_ack  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(REF_LEN);
                end else if (req) begin
                    state_d  = ST_ROW;
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RCD);
                end
            end
            ST_ROW: begin
                if (tmr_expired) begin
                    state_d  = ST_COL;
                    tmr_load = 1'b1;
                end
            end
            ST_COL: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (late_q) begin
                        state_d = ST_CAS_ONLY;
                    end else begin
                        state_d = ST_STROBE;
                        tmr_val = TMR_W'(T_CAS);
                    end
                end
            end
            ST_CAS_ONLY: begin
                if (tmr_expired) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_CAS);
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    state_d  = ST_PRECHARGE;
                    finish   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RP);
                end
            end
            ST_REFRESH: begin
                if (tmr_expired) begin
                    state_d  = ST_PRECHARGE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RP);
                end
            end
            ST_PRECHARGE: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture, refresh row capture and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            is_wr_q   <= 1'b0;
            late_q    <= 1'b0;
            rd_data_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                is_wr_q <= req_we;
                late_q  <= late_mode;
            end else if (ref_ack) begin
                addr_q  <= {ref_row, {(ADDR_W - PIN_W){1'b0}}};
                is_wr_q <= 1'b0;
            end
            if (finish && !is_wr_q) begin
                rd_data_q <= dram_dq_in;
            end
        end
    end

    // Pin outputs decoded from the current state
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_oe_n  = 1'b1;
        dram_dq_oe = 1'b0;
        dram_addr  = '0;
        unique case (state_q)
            ST_ROW, ST_REFRESH: begin
                dram_ras_n = 1'b0;
                dram_addr  = addr_q[ADDR_W-1:PIN_W];
            end
            ST_COL: begin
                dram_ras_n = 1'b0;
                dram_addr  = addr_q[PIN_W-1:0];
                dram_dq_oe = is_wr_q;
                dram_we_n  = !(is_wr_q && !late_q);
                dram_oe_n  = !(!is_wr_q && !late_q);
            end
            ST_CAS_ONLY: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_addr  = addr_q[PIN_W-1:0];
                dram_dq_oe = is_wr_q;
            end
            ST_STROBE: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_addr  = addr_q[PIN_W-1:0];
                dram_dq_oe = is_wr_q;
                dram_we_n  = !is_wr_q;
                dram_oe_n  = is_wr_q;
            end
            ST_IDLE, ST_PRECHARGE: begin
                dram_ras_n = 1'b1;
            end
            default: dram_ras_n = 1'b1;
        endcase
    end

    assign dram_dq_out = wdata_q;
    assign rd_data     = rd_data_q;
    assign done        = done_q;

endmodule

// File: rtl/dram_async_ctrl_chk.sv
module dram_async_ctrl_chk #(
    parameter int T_RP  = 3,
    parameter int T_CAS = 2
) (
    input logic clk,
    input logic rst_n,
    input logic late_mode,
    input logic ras_n,
    input logic cas_n,
    input logic oe_n,
    input logic we_n,
    input logic dq_oe,
    input logic done
);

    localparam int CW = $clog2(T_RP + T_CAS + 2) + 1;

    logic [CW-1:0] ras_hi_cnt;
    logic [CW-1:0] cas_lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_hi_cnt <= CW'(T_RP);
            cas_lo_cnt <= '0;
        end else begin
            if (!ras_n) begin
                ras_hi_cnt <= '0;
            end else if (ras_hi_cnt != '1) begin
                ras_hi_cnt <= ras_hi_cnt + CW'(1);
            end
            if (cas_n) begin
                cas_lo_cnt <= '0;
            end else if (cas_lo_cnt != '1) begin
                cas_lo_cnt <= cas_lo_cnt + CW'(1);
            end
        end
    end

    assert_cas_under_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_early_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !late_mode) |-> (!$past(oe_n) || !$past(we_n)));

    assert_late_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && late_mode) |-> (oe_n && we_n));

    assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    assert_enables_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    assert_ras_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_cnt >= CW'(T_RP)));

    assert_cas_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (cas_lo_cnt >= CW'(T_CAS)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ras_n && cas_n && oe_n && we_n));

endmodule

bind dram_async_ctrl dram_async_ctrl_chk #(
    .T_RP  (T_RP),
    .T_CAS (T_CAS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .late_mode (late_mode),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .oe_n      (dram_oe_n),
    .we_n      (dram_we_n),
    .dq_oe     (dram_dq_oe),
    .done      (done)
);

// File: tb/dram_async_ctrl_tb.sv
module dram_async_ctrl_tb;

    localparam int CLK_HZ  = 1_280_000;   // scaled so one refresh falls due every 20 cycles
    localparam int REF_INT = (CLK_HZ / 1000) * 8 / 512;
    localparam int T_RP    = 2;
    localparam int T_RCD   = 2;
    localparam int T_CAS   = 2;
    localparam int GAP_MAX = REF_INT + 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        late_mode = 1'b0;
    logic [7:0]  rd_data;
    logic        done;
    logic [8:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [7:0]  dram_dq_out;
    logic        dram_dq_oe;
    logic [7:0]  dram_dq_in;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    dram_async_ctrl #(
        .CLK_HZ (CLK_HZ), .REFRESH_MS (8), .ADDR_W (18), .DATA_W (8),
        .T_RP (T_RP), .T_RCD (T_RCD), .T_CAS (T_CAS)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req (req), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata), .late_mode (late_mode),
        .rd_data (rd_data), .done (done), .dram_addr (dram_addr),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n),
        .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
        .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe),
        .dram_dq_in (dram_dq_in)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] init_val(input logic [17:0] a);
        return a[7:0] ^ a[17:10] ^ 8'h5A;
    endfunction

    // Behavioural device and bench reference contents
    logic [7:0] dev_mem [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] ref_read(input logic [17:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
    endfunction

    // Pin monitor and device model, sampled away from the active edge
    logic [8:0] mon_row = '0, mon_col = '0;
    logic       p_ras = 1'b1, p_cas = 1'b1;
    logic       mon_late_seen = 1'b0, win_cas = 1'b0;
    int         ras_hi = 100, ras_lo = 0, cas_lo = 0;
    int         cyc = 0, ras_fall_cyc = 0, last_ref_cyc = -1;
    int         ref_count = 0;
    logic [8:0] exp_ref_row = '0;
    bit         wrap_seen = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                check(ras_hi >= T_RP, "R7 ras high width", ras_hi, T_RP);
                mon_row = dram_addr;
                win_cas = 1'b0;
                ras_fall_cyc = cyc;
            end
            if (p_cas && !dram_cas_n) begin
                check(ras_lo >= T_RCD, "R2 row-to-column delay", ras_lo, T_RCD);
                mon_col = dram_addr;
                win_cas = 1'b1;
                mon_late_seen = dram_oe_n && dram_we_n;
            end
            if (!p_cas && dram_cas_n) begin
                check(cas_lo >= T_CAS, "R7 cas low width", cas_lo, T_CAS);
            end
            if (!p_ras && dram_ras_n && !win_cas) begin
                check(mon_row == exp_ref_row, "R8 refresh row order", mon_row, exp_ref_row);
                if (exp_ref_row == 9'd511) wrap_seen = 1;
                exp_ref_row = exp_ref_row + 9'd1;
                if (last_ref_cyc >= 0)
                    check(ras_fall_cyc - last_ref_cyc <= GAP_MAX, "R9 refresh gap",
                          ras_fall_cyc - last_ref_cyc, GAP_MAX);
                last_ref_cyc = ras_fall_cyc;
                ref_count++;
            end
            if (!dram_we_n && !dram_ras_n && !dram_cas_n) begin
                check(dram_dq_oe, "R5 write data driven", dram_dq_oe, 1);
                dev_mem[int'({mon_row, mon_col})] = dram_dq_out;
            end
            if (dram_dq_oe && !dram_oe_n)
                check(0, "R5 drive during read", 1, 0);
        end
        ras_hi = dram_ras_n ? ras_hi + 1 : 0;
        ras_lo = dram_ras_n ? 0 : ras_lo + 1;
        cas_lo = dram_cas_n ? 0 : cas_lo + 1;
        p_ras = dram_ras_n;
        p_cas = dram_cas_n;
    end

    always @* begin
        if (!dram_ras_n && !dram_cas_n && !dram_oe_n) begin
            if (dev_mem.exists(int'({mon_row, mon_col})))
                dram_dq_in = dev_mem[int'({mon_row, mon_col})];
            else
                dram_dq_in = init_val({mon_row, mon_col});
        end else begin
            dram_dq_in = 8'h00;
        end
    end

    task automatic do_access(input logic wr, input logic [17:0] a, input logic [7:0] d, input logic late);
        int waited = 0;
        logic [7:0] exp_rd;
        exp_rd = ref_read(a);
        late_mode = late;
        req_we = wr;
        req_addr = a;
        req_wdata = d;
        req = 1'b1;
        do begin
            @(negedge clk);
            waited++;
        end while (!done && waited < 200);
        req = 1'b0;
        check(done, "R10 done seen", done, 1);
        check(mon_row == a[17:9], "R2 row half", mon_row, a[17:9]);
        check(mon_col == a[8:0], "R2 column half", mon_col, a[8:0]);
        if (late) check(mon_late_seen == 1'b1, "R4 late ordering", mon_late_seen, 1);
        else      check(mon_late_seen == 1'b0, "R3 early ordering", mon_late_seen, 0);
        if (wr) ref_mem[int'(a)] = d;
        else    check(rd_data == exp_rd, "R6 read data", rd_data, exp_rd);
        @(negedge clk);
        check(!done, "R10 done one cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seed;
        int start_cnt;
        seed = $urandom(32'h0DAC_0017);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        check(!dram_dq_oe && !done, "R1 drive and done low", {dram_dq_oe, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners: address extremes in both styles
        do_access(1'b1, 18'h3FFFF, 8'hA5, 1'b0);
        do_access(1'b0, 18'h3FFFF, 8'h00, 1'b1);
        do_access(1'b1, 18'h00000, 8'h3C, 1'b1);
        do_access(1'b0, 18'h00000, 8'h00, 1'b0);
        do_access(1'b0, 18'h201FF, 8'h00, 1'b0);   // unwritten: initial contents
        do_access(1'b1, 18'h201FF, 8'hC3, 1'b1);
        do_access(1'b0, 18'h201FF, 8'h00, 1'b1);

        // Random back-to-back traffic over a small address pool (R9 under load)
        for (int i = 0; i < 200; i++) begin
            logic [17:0] a;
            a = {$urandom_range(0, 3) == 0 ? 9'h1FF : 9'($urandom_range(0, 7)),
                 9'($urandom_range(0, 15))};
            do_access(1'($urandom_range(0, 1)), a, 8'($urandom), 1'($urandom_range(0, 1)));
        end

        // Refresh rate while idle
        start_cnt = ref_count;
        repeat (REF_INT * 10) @(negedge clk);
        check((ref_count - start_cnt) >= 9 && (ref_count - start_cnt) <= 11,
              "R8 refresh rate", ref_count - start_cnt, 10);

        // Let the row pointer wrap
        for (int k = 0; k < 12000 && ref_count < 530; k++) @(negedge clk);
        check(wrap_seen, "R8 row wrap 511 to 0", wrap_seen, 1);

        // Contents survive the idle period
        do_access(1'b0, 18'h201FF, 8'h00, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule